// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block sequences a volatile memory that has a nonvolatile twin behind every cell. It watches two supply-status inputs. The first is a power-on-reset indication, and while it is low the block is held fully reset. The second is a supply-trip indication, which passes through a two-flop synchronizer and an N-cycle glitch filter before it can act. When the filtered trip goes low, host access is shut off at once. The switch to the main supply is opened so the block runs from its reserve capacitor. A single strobe then copies the whole volatile array into its shadow in one parallel step, and a cycle timer holds the block in that phase for the store duration.

When the filtered trip comes back high, a recall strobe copies the whole shadow back into the volatile array, again in one step and under its own timer. After the recall ends, the supply switch closes and host access reopens. A supply that returns while a store is still running does not cut the store short. The block finishes the store, waits, and then recalls in the usual way. After reset, the first filtered trip-high also starts a recall.

A small mirrored array model sits inside the block and serves both the host port and the copy strobes. While the supply is gone, its volatile half is overwritten with a fixed loss pattern. A saturating counter records how many stores have completed.

Top module: `pf_backup_ctrl`

## Requirements
- R1: While `rst` is high or `por_ok` is low, the next sampled state is: `seq_status` = 2 (waiting for supply), `host_ready` = 0, `supply_sw` = 0 and `store_count` = 0.
- R2: A low pulse on `trip_ok` shorter than FILT_CYC cycles leaves `seq_status` at 0. A low level held long enough puts `seq_status` at 1 exactly FILT_CYC+3 cycles after the input changes.
- R3: In the first store cycle, `host_ready` and `supply_sw` are 0. Over the whole store phase, `store_stb` is high for exactly one cycle (the first one), and `store_stb` and `recall_stb` are never high together.
- R4: The store phase (`seq_status` = 1) lasts exactly STORE_CYC cycles, even when `trip_ok` returns high during it. The block then enters the wait state (`seq_status` = 2).
- R5: A recall (`seq_status` = 3) starts only from the wait state once the filtered trip is high. It lasts exactly RECALL_CYC cycles with `host_ready` = 0, and `recall_stb` is high only in its first cycle. After it, `seq_status` = 0 with `supply_sw` = 1 and `host_ready` = 1.
- R6: After a store, a supply loss (the volatile cells are overwritten with LOSS_FILL) and a recall, every address reads the value it held when the store began.
- R7: A host write presented while `host_ready` = 0 does not change the array.
- R8: `store_count` increments by one at the end of each completed store and saturates at 2^CNT_W-1.
- R9: The `seq_status` encoding is 0 = normal access, 1 = store, 2 = waiting for supply, 3 = recall.
- R10: A host read accepted while `host_ready` = 1 shows the addressed word on `host_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok | input | 1 | Supply above power-on-reset level; low forces full reset |
| trip_ok | input | 1 | Supply above trip level (asynchronous) |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered host read data |
| host_ready | output | 1 | Host access allowed |
| supply_sw | output | 1 | Main-supply switch closed |
| store_stb | output | 1 | One-cycle parallel store strobe |
| recall_stb | output | 1 | One-cycle parallel recall strobe |
| seq_status | output | 2 | Sequencer state code |
| store_count | output | CNT_W | Saturating count of completed stores |

## Verification
A wrong sequencer state shows on `seq_status`, `host_ready` and `supply_sw` in the very next sampled cycle. A timer that loads or counts wrongly makes the measured store or recall window differ from its parameter by at least one cycle. An extra, missing or misplaced copy strobe shows up only later, as corrupted data when the addresses are read back after the recall returns the block to normal. A leak in write gating shows in the same read-back.

// File: rtl/pf_backup_pkg.sv
package pf_backup_pkg;

    typedef enum logic [1:0] {
        SEQ_NORMAL = 2'd0,
        SEQ_STORE  = 2'd1,
        SEQ_WAIT   = 2'd2,
        SEQ_RECALL = 2'd3
    } seq_state_e;

    function automatic logic host_open(input seq_state_e s);
        return s == SEQ_NORMAL;
    endfunction

    function automatic logic [1:0] state_code(input seq_state_e s);
        return logic'(s[1]) ? {1'b1, s[0]} : {1'b0, s[0]};
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pf_trip_filter.sv
module pf_trip_filter #(
    parameter int unsigned FILT_CYC = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic          sync1_q, sync2_q, level_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            level_q <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            if (sync2_q != level_q) begin
                if (run_q == CW'(FILT_CYC - 1)) begin
                    level_q <= sync2_q;
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign level_o = level_q;

    // R2: the filtered level moves only toward a synchronized value that differed from it
    assert_filter_follows_R2: assert property (@(posedge clk) disable iff (clr)
        (level_q != $past(level_q)) |-> ($past(sync2_q) == level_q));

endmodule

// File: rtl/pf_seq_fsm.sv
module pf_seq_fsm
    import pf_backup_pkg::*;
#(
    parameter int unsigned STORE_CYC  = 2_500_000,
    parameter int unsigned RECALL_CYC = 137_500,
    parameter int unsigned CNT_W      = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             trip_f_i,
    output seq_state_e       state_o,
    output logic             store_stb_o,
    output logic             recall_stb_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned TW = $clog2(max2(STORE_CYC, RECALL_CYC) + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_e       state_q, state_d;
    logic [TW-1:0]    tmr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmr_done;

    assign tmr_done = (tmr_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_NORMAL: if (!trip_f_i) state_d = SEQ_STORE;
            SEQ_STORE:  if (tmr_done)  state_d = SEQ_WAIT;
            SEQ_WAIT:   if (trip_f_i)  state_d = SEQ_RECALL;
            SEQ_RECALL: if (tmr_done)  state_d = SEQ_NORMAL;
            default:                   state_d = SEQ_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q      <= SEQ_WAIT;
            tmr_q        <= '0;
            cnt_q        <= '0;
            store_stb_o  <= 1'b0;
            recall_stb_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            store_stb_o  <= (state_d == SEQ_STORE)  && (state_q != SEQ_STORE);
            recall_stb_o <= (state_d == SEQ_RECALL) && (state_q != SEQ_RECALL);
            if (state_d == SEQ_STORE && state_q != SEQ_STORE)
                tmr_q <= TW'(STORE_CYC - 1);
            else if (state_d == SEQ_RECALL && state_q != SEQ_RECALL)
                tmr_q <= TW'(RECALL_CYC - 1);
            else if (!tmr_done)
                tmr_q <= tmr_q - 1'b1;
            if (state_q == SEQ_STORE && tmr_done && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign count_o = cnt_q;

    // R3: a store strobe appears only in the first cycle of a store
    assert_store_stb_first_R3: assert property (@(posedge clk) disable iff (clr)
        store_stb_o |-> (state_q == SEQ_STORE && $past(state_q) != SEQ_STORE));

    // R3: the two copy strobes never overlap
    assert_no_dual_stb_R3: assert property (@(posedge clk) disable iff (clr)
        !(store_stb_o && recall_stb_o));

    // R5: a recall is entered only from the wait state
    assert_recall_from_wait_R5: assert property (@(posedge clk) disable iff (clr)
        (state_q == SEQ_RECALL && $past(state_q) != SEQ_RECALL) |-> ($past(state_q) == SEQ_WAIT));

    // R4: a store never ends straight into normal access
    assert_store_exit_R4: assert property (@(posedge clk) disable iff (clr)
        ($past(state_q) == SEQ_STORE && state_q != SEQ_STORE) |-> (state_q == SEQ_WAIT));

    // R8: the count saturates and changes only as a store ends
    assert_count_sat_R8: assert property (@(posedge clk) disable iff (clr)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || clr));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (clr)
        (cnt_q != $past(cnt_q)) |-> ($past(state_q) == SEQ_STORE && state_q == SEQ_WAIT));

endmodule

// File: rtl/pf_mirror_array.sv
module pf_mirror_array #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    parameter logic [DW-1:0] LOSS_FILL = '1,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          store_i,
    input  logic          recall_i,
    input  logic          lose_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] vol_word [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : gen_cell
        logic [DW-1:0] vol_q;
        logic [DW-1:0] nv_q;

        always_ff @(posedge clk) begin
            if (recall_i)
                vol_q <= nv_q;
            else if (lose_i)
                vol_q <= LOSS_FILL;
            else if (wr_i && addr_i == AW'(i))
                vol_q <= wdata_i;
            if (store_i)
                nv_q <= vol_q;
        end

        assign vol_word[i] = vol_q;
    end

    always_ff @(posedge clk) begin
        if (clr)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= vol_word[addr_i];
    end

    // R7: no host write may land while the array is being copied or has lost supply
    always_ff @(posedge clk) begin
        if (!clr) begin
            assert_no_write_in_copy_R7: assert (!(wr_i && (store_i || recall_i || lose_i)));
        end
    end

endmodule

// File: rtl/pf_backup_ctrl.sv
module pf_backup_ctrl
    import pf_backup_pkg::*;
#(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned DW         = 8,
    parameter int unsigned FILT_CYC   = 4,
    parameter int unsigned STORE_CYC  = 2_500_000,
    parameter int unsigned RECALL_CYC = 137_500,
    parameter int unsigned CNT_W      = 8,
    parameter logic [DW-1:0] LOSS_FILL = '1,
    localparam int unsigned AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_ok,
    input  logic             trip_ok,
    input  logic             host_en,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_ready,
    output logic             supply_sw,
    output logic             store_stb,
    output logic             recall_stb,
    output logic [1:0]       seq_status,
    output logic [CNT_W-1:0] store_count
);
    logic       clr;
    logic       trip_f;
    seq_state_e state;
    logic       open;

    assign clr = rst | ~por_ok;

    pf_trip_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk     (clk),
        .clr     (clr),
        .raw_i   (trip_ok),
        .level_o (trip_f)
    );

    pf_seq_fsm #(
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .clr          (clr),
        .trip_f_i     (trip_f),
        .state_o      (state),
        .store_stb_o  (store_stb),
        .recall_stb_o (recall_stb),
        .count_o      (store_count)
    );

    assign open = host_open(state);

    pf_mirror_array #(
        .DEPTH     (DEPTH),
        .DW        (DW),
        .LOSS_FILL (LOSS_FILL)
    ) u_array (
        .clk      (clk),
        .clr      (clr),
        .wr_i     (host_en & host_we & open),
        .rd_i     (host_en & ~host_we & open),
        .addr_i   (host_addr),
        .wdata_i  (host_wdata),
        .store_i  (store_stb),
        .recall_i (recall_stb),
        .lose_i   (state == SEQ_WAIT),
        .rdata_o  (host_rdata)
    );

    assign host_ready = open;
    assign supply_sw  = open;
    assign seq_status = state_code(state);

    // R5: the supply switch closes only as a recall finishes
    assert_switch_close_R5: assert property (@(posedge clk) disable iff (clr)
        $rose(supply_sw) |-> ($past(seq_status) == 2'd3));

endmodule

// File: tb/tb_pf_backup_ctrl.sv
module tb_pf_backup_ctrl;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int FILT  = 4;
    localparam int ST    = 40;
    localparam int RC    = 12;
    localparam int CW    = 3;
    localparam logic [DW-1:0] FILL = 8'hFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_ok = 1'b1;
    logic trip_ok = 1'b0;
    logic host_en = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic host_ready, supply_sw, store_stb, recall_stb;
    logic [1:0] seq_status;
    logic [CW-1:0] store_count;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [DW-1:0] exp_mem [DEPTH];
    int exp_cnt = 0;

    always #2 clk = ~clk;

    pf_backup_ctrl #(
        .DEPTH(DEPTH), .DW(DW), .FILT_CYC(FILT), .STORE_CYC(ST),
        .RECALL_CYC(RC), .CNT_W(CW), .LOSS_FILL(FILL)
    ) dut (
        .clk(clk), .rst(rst), .por_ok(por_ok), .trip_ok(trip_ok),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
        .supply_sw(supply_sw), .store_stb(store_stb), .recall_stb(recall_stb),
        .seq_status(seq_status), .store_count(store_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int sat_next(input int c);
        return (c == (1 << CW) - 1) ? c : c + 1;
    endfunction

    task automatic host_write(input int a, input logic [DW-1:0] d);
        host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = d;
        tick();
        host_en = 0; host_we = 0;
    endtask

    task automatic host_read(input int a, output logic [DW-1:0] d);
        host_en = 1; host_we = 0; host_addr = AW'(a);
        tick();
        d = host_rdata;
        host_en = 0;
    endtask

    task automatic fill_random();
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] v;
            v = DW'($urandom_range(0, 254));
            exp_mem[a] = v;
            host_write(a, v);
        end
    endtask

    task automatic verify_all(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            logic [DW-1:0] d;
            host_read(a, d);
            chk(d == exp_mem[a], req, int'(d), int'(exp_mem[a]));
        end
    endtask

    // run a recall to completion from the current state; writes are attempted throughout
    task automatic run_recall();
        int n, rlen, rstb;
        n = 0;
        while (seq_status != 2'd3 && n < 200) begin
            tick(); n++;
        end
        chk(seq_status == 2'd3, "R5 recall entered", int'(seq_status), 3);
        chk(recall_stb == 1'b1, "R5 recall strobe first cycle", int'(recall_stb), 1);
        chk(host_ready == 1'b0, "R5 blocked in recall", int'(host_ready), 0);
        rlen = 1; rstb = 1;
        host_en = 1; host_we = 1; host_addr = '0; host_wdata = ~exp_mem[0];
        forever begin
            tick();
            if (seq_status != 2'd3) break;
            rlen++;
            rstb += int'(recall_stb);
            if (host_ready) begin
                chk(0, "R5 host_ready low in recall", 1, 0);
            end
        end
        host_en = 0; host_we = 0;
        chk(rlen == RC, "R5 recall length", rlen, RC);
        chk(rstb == 1, "R5 single recall strobe", rstb, 1);
        chk(seq_status == 2'd0, "R9 normal after recall", int'(seq_status), 0);
        chk(supply_sw == 1'b1 && host_ready == 1'b1, "R5 switch and access restored",
            int'({supply_sw, host_ready}), 3);
    endtask

    task automatic power_fail(input int hold_low, input bit early_return);
        int n, slen, sstb, dual;
        trip_ok = 0;
        n = 0;
        do begin
            tick(); n++;
        end while (seq_status != 2'd1 && n < 100);
        chk(n == FILT + 3, "R2 store entry latency", n, FILT + 3);
        chk(host_ready == 1'b0, "R3 access suspended", int'(host_ready), 0);
        chk(supply_sw == 1'b0, "R3 supply switch open", int'(supply_sw), 0);
        slen = 1; sstb = int'(store_stb); dual = 0;
        forever begin
            tick();
            if (seq_status != 2'd1) break;
            slen++;
            sstb += int'(store_stb);
            if (store_stb && recall_stb) dual++;
            if (early_return && slen == 5) trip_ok = 1;
        end
        chk(sstb == 1, "R3 single store strobe", sstb, 1);
        chk(dual == 0, "R3 strobes exclusive", dual, 0);
        chk(slen == ST, "R4 store length", slen, ST);
        chk(seq_status == 2'd2, "R4 wait after store", int'(seq_status), 2);
        exp_cnt = sat_next(exp_cnt);
        chk(int'(store_count) == exp_cnt, "R8 store count", int'(store_count), exp_cnt);
        if (!early_return) begin
            for (int i = 0; i < hold_low; i++) begin
                tick();
                if (seq_status != 2'd2 || host_ready) begin
                    chk(0, "R9 held in wait while supply low", int'(seq_status), 2);
                end
            end
            trip_ok = 1;
        end
        run_recall();
        // R6 R7: contents back as before the store; blocked writes to address 0 left no trace
        verify_all("R6 R7 recalled data");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1: reset state
        chk(seq_status == 2'd2, "R1 reset status", int'(seq_status), 2);
        chk(host_ready == 1'b0 && supply_sw == 1'b0, "R1 reset gating", int'({host_ready, supply_sw}), 0);
        chk(store_count == '0, "R1 reset count", int'(store_count), 0);
        rst = 0;
        trip_ok = 1;
        run_recall();

        fill_random();
        // R10: read back in normal operation
        verify_all("R10 normal read");

        // R2: glitches shorter than the filter are ignored
        for (int g = 0; g < 4; g++) begin
            int len;
            int bad;
            len = (g == 0) ? FILT - 1 : $urandom_range(1, FILT - 1);
            trip_ok = 0;
            repeat (len) tick();
            trip_ok = 1;
            bad = 0;
            repeat (FILT + 6) begin
                tick();
                if (seq_status != 2'd0) bad++;
            end
            chk(bad == 0, "R2 glitch ignored", bad, 0);
        end

        // directed: supply returns mid-store
        power_fail(0, 1'b1);

        // constrained random rounds, running the count into saturation
        for (int r = 0; r < 8; r++) begin
            fill_random();
            power_fail($urandom_range(2, 30), 1'b0);
        end
        chk(int'(store_count) == (1 << CW) - 1, "R8 saturated", int'(store_count), (1 << CW) - 1);

        // R1: power-on reset drop is a full reset
        por_ok = 0;
        tick();
        chk(seq_status == 2'd2 && store_count == '0, "R1 por reset",
            int'({store_count, seq_status}), 2);
        chk(host_ready == 1'b0 && supply_sw == 1'b0, "R1 por gating", int'({host_ready, supply_sw}), 0);
        tick();
        por_ok = 1;
        // R5: first filtered trip-high after reset recalls the shadow
        run_recall();
        verify_all("R6 data after power-on recall");
        exp_cnt = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule